// File: doc/BRIEF.md
# FIFO Status Register Bank

This block is a sixteen-slot, byte-wide register bank on a plain address/data bus. It fronts a shared transmit/receive byte FIFO of 4096 entries. The storage array lives outside the block. Here the FIFO is kept as an occupancy counter plus sticky error flags. The block issues the write and read strobes that the external storage needs, and it passes the popped byte back to the pusher and popper side.

Software configures the line mode, the baud divisor, the control settings, the DPLL and the digital receiver settings through read/write registers. It watches the FIFO through a read-only status byte and a two-byte occupancy count. The only write with a side effect is a single clear bit inside the status byte, which empties the FIFO and drops its error flags. No FIFO traffic is accepted until the enable bit in the mode register is set.

Top module: `fifo_stat_ctrl`

## Requirements
- R1: After synchronous reset, every register reads 0x00, except two. The sensitivity register reads the revision value 0x05, and the status register reads 0x04 (empty).
- R2: A read strobe returns the addressed register on `bus_rdata` one clock later. Addresses 1 (mode), 2 (baud), 3 (control), 8 (DPLL) and 9 (digital control) store and return all eight written bits.
- R3: Writes to addresses 0 and 10 through 15 change nothing, and reads from them return 0x00. Writes to the status register (5) and to the count registers (6, 7) change no readable bit.
- R4: Sensitivity register (4) bits 2:0 always read the fixed revision 3'b101. Bits 7:3 are writable.
- R5: While mode bit 1 is 0, push and pop have no effect on the occupancy, the flags or the strobes.
- R6: With mode bit 1 set, an accepted push adds one to the occupancy, an accepted pop subtracts one, and both together leave it unchanged. Count low (6) holds occupancy bits 7:0, and count high (7) holds bits 12:8 in its bits 4:0.
- R7: A push while the occupancy is 4096 is dropped (`fifo_we` stays 0) and sets status bit 5 (overflow), which stays set until cleared.
- R8: A pop while empty is refused (`fifo_re` stays 0), sets status bit 6 (underflow), and drives `pop_data` to 0x00 one clock later.
- R9: Writing status with bit 3 set makes the occupancy 0 and clears overflow and underflow by the next read. A push in that same cycle is dropped. Bit 3 always reads 0.
- R10: Status bit 4 becomes 1 after an accepted push alone and 0 after an accepted pop alone. It holds otherwise.
- R11: Status bit 2 reads 1 exactly when the occupancy is 0. Status bits 7, 1 and 0 show the `frame_end`, `rx_err` and `tx_err` inputs at the read.
- R12: `fifo_we` and `fifo_re` are high in exactly the cycles in which a push or pop is accepted. An accepted pop places `fifo_rdata` on `pop_data` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| push | input | 1 | Request to add one byte to the FIFO |
| pop | input | 1 | Request to remove one byte from the FIFO |
| fifo_rdata | input | 8 | Byte presented by the external storage for a pop |
| frame_end | input | 1 | End-of-frame indication shown in status |
| rx_err | input | 1 | Receive error indication shown in status |
| tx_err | input | 1 | Transmit error indication shown in status |
| fifo_we | output | 1 | Storage write strobe for an accepted push |
| fifo_re | output | 1 | Storage read strobe for an accepted pop |
| pop_data | output | 8 | Byte returned by the last pop, 0x00 on underflow |

## Verification
A table of write-then-read vectors covers every address. Each vector separates the fully stored registers from the partly fixed sensitivity register, and both of those from the read-only and unmapped slots.

The FIFO model is tried with five traffic patterns:
- pushes while disabled, which tell gating apart from counting;
- pushes alone and pops alone, which move both the count and the direction bit;
- simultaneous push and pop, which must hold both the count and the direction;
- a fill to 4096 plus one extra push, which exposes a count carry into the high register and the overflow flag;
- a pop on an empty FIFO and a clear written in the same cycle as a push, which show which event wins.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int DW = 8;
  localparam int AW = 4;

  localparam logic [AW-1:0] A_MODE = 4'd1;
  localparam logic [AW-1:0] A_BAUD = 4'd2;
  localparam logic [AW-1:0] A_CTRL = 4'd3;
  localparam logic [AW-1:0] A_SENS = 4'd4;
  localparam logic [AW-1:0] A_STAT = 4'd5;
  localparam logic [AW-1:0] A_CNTL = 4'd6;
  localparam logic [AW-1:0] A_CNTH = 4'd7;
  localparam logic [AW-1:0] A_DPLL = 4'd8;
  localparam logic [AW-1:0] A_DIG  = 4'd9;
  localparam logic [AW-1:0] A_LAST = 4'd9;

  // status bit positions
  localparam int ST_EOF = 7;
  localparam int ST_UNF = 6;
  localparam int ST_OVF = 5;
  localparam int ST_DIR = 4;
  localparam int ST_CLR = 3;
  localparam int ST_EMP = 2;
  localparam int ST_RXE = 1;
  localparam int ST_TXE = 0;

  // mode bit that opens the FIFO
  localparam int MD_FIFO_ON = 1;
endpackage

// File: rtl/fsc_regbank.sv
module fsc_regbank
  import fsc_pkg::*;
#(
  parameter logic [2:0] REV = 3'b101
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] stat_byte,
  input  logic [DW-1:0] cnt_lo,
  input  logic [DW-1:0] cnt_hi,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] mode_q,
  output logic          clear_pulse
);
  localparam int NRW = 5;
  localparam int REVW = 3;
  localparam logic [AW-1:0] RW_ADDR [NRW] = '{A_MODE, A_BAUD, A_CTRL, A_DPLL, A_DIG};

  logic [DW-1:0]      rw_q [NRW];
  logic [DW-REVW-1:0] sens_hi;
  logic [DW-1:0]      rd_next;

  for (genvar g = 0; g < NRW; g++) begin : g_rw
    always_ff @(posedge clk) begin
      if (rst) begin
        rw_q[g] <= '0;
      end else if (wr && addr == RW_ADDR[g]) begin
        rw_q[g] <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sens_hi <= '0;
    end else if (wr && addr == A_SENS) begin
      sens_hi <= wdata[DW-1:REVW];
    end
  end

  assign clear_pulse = wr && (addr == A_STAT) && wdata[ST_CLR];
  assign mode_q      = rw_q[0];

  always_comb begin
    rd_next = '0;
    for (int i = 0; i < NRW; i++) begin
      if (addr == RW_ADDR[i]) rd_next = rw_q[i];
    end
    case (addr)
      A_SENS:  rd_next = {sens_hi, REV};
      A_STAT:  rd_next = stat_byte;
      A_CNTL:  rd_next = cnt_lo;
      A_CNTH:  rd_next = cnt_hi;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd) begin
      rdata <= rd_next;
    end
  end
endmodule

// File: rtl/fsc_occupancy.sv
module fsc_occupancy #(
  parameter int DEPTH = 4096,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          clear,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] fifo_rdata,
  output logic [CW-1:0] count,
  output logic          ovf,
  output logic          unf,
  output logic          dir_tx,
  output logic          empty,
  output logic          we,
  output logic          re,
  output logic [DW-1:0] pop_data
);
  localparam logic [CW-1:0] FULL_AT = CW'(DEPTH);

  logic full;
  logic push_req;
  logic pop_req;

  assign full     = (count == FULL_AT);
  assign empty    = (count == '0);
  assign push_req = en && push && !clear;
  assign pop_req  = en && pop && !clear;
  assign we       = push_req && !full;
  assign re       = pop_req && !empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
      dir_tx <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
      unf   <= 1'b0;
    end else begin
      count <= count + CW'(we) - CW'(re);
      if (push_req && full)  ovf <= 1'b1;
      if (pop_req && empty)  unf <= 1'b1;
      if (we && !re)         dir_tx <= 1'b1;
      else if (re && !we)    dir_tx <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pop_data <= '0;
    end else if (re) begin
      pop_data <= fifo_rdata;
    end else if (pop_req && empty) begin
      pop_data <= '0;
    end
  end
endmodule

// File: rtl/fifo_stat_ctrl.sv
module fifo_stat_ctrl
  import fsc_pkg::*;
#(
  parameter int         DEPTH = 4096,
  parameter logic [2:0] REV   = 3'b101,
  localparam int        CW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          push,
  input  logic          pop,
  input  logic [DW-1:0] fifo_rdata,
  input  logic          frame_end,
  input  logic          rx_err,
  input  logic          tx_err,
  output logic          fifo_we,
  output logic          fifo_re,
  output logic [DW-1:0] pop_data
);
  logic [DW-1:0] mode_q;
  logic          mode_en;
  logic          clear_wr;
  logic [CW-1:0] occ_count;
  logic          ovf_flag;
  logic          unf_flag;
  logic          dir_flag;
  logic          empty_flag;
  logic [DW-1:0] stat_byte;
  logic [DW-1:0] cnt_lo;
  logic [DW-1:0] cnt_hi;

  assign mode_en = mode_q[MD_FIFO_ON];

  always_comb begin
    stat_byte         = '0;
    stat_byte[ST_EOF] = frame_end;
    stat_byte[ST_UNF] = unf_flag;
    stat_byte[ST_OVF] = ovf_flag;
    stat_byte[ST_DIR] = dir_flag;
    stat_byte[ST_EMP] = empty_flag;
    stat_byte[ST_RXE] = rx_err;
    stat_byte[ST_TXE] = tx_err;
  end

  assign cnt_lo = occ_count[DW-1:0];
  assign cnt_hi = DW'(occ_count >> DW);

  fsc_regbank #(.REV(REV)) u_regs (
    .clk         (clk),
    .rst         (rst),
    .wr          (bus_wr),
    .rd          (bus_rd),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .stat_byte   (stat_byte),
    .cnt_lo      (cnt_lo),
    .cnt_hi      (cnt_hi),
    .rdata       (bus_rdata),
    .mode_q      (mode_q),
    .clear_pulse (clear_wr)
  );

  fsc_occupancy #(.DEPTH(DEPTH), .DW(DW)) u_occ (
    .clk        (clk),
    .rst        (rst),
    .en         (mode_en),
    .clear      (clear_wr),
    .push       (push),
    .pop        (pop),
    .fifo_rdata (fifo_rdata),
    .count      (occ_count),
    .ovf        (ovf_flag),
    .unf        (unf_flag),
    .dir_tx     (dir_flag),
    .empty      (empty_flag),
    .we         (fifo_we),
    .re         (fifo_re),
    .pop_data   (pop_data)
  );
endmodule

// File: rtl/fsc_checker.sv
module fsc_checker
  import fsc_pkg::*;
#(
  parameter int DEPTH = 4096,
  parameter int CW    = 13
) (
  input logic          clk,
  input logic          rst,
  input logic          bus_wr,
  input logic          bus_rd,
  input logic [AW-1:0] bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [DW-1:0] bus_rdata,
  input logic          push,
  input logic          pop,
  input logic          mode_en,
  input logic          clear_wr,
  input logic [CW-1:0] occ_count,
  input logic          ovf_flag,
  input logic          unf_flag,
  input logic          fifo_we,
  input logic          fifo_re,
  input logic [DW-1:0] pop_data
);
  logic clr_seen;
  logic unmapped;
  assign clr_seen = bus_wr && (bus_addr == A_STAT) && bus_wdata[ST_CLR];
  assign unmapped = (bus_addr == '0) || (bus_addr > A_LAST);

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    clr_seen |=> (occ_count == '0) && !ovf_flag && !unf_flag); // R9

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    occ_count <= CW'(DEPTH)); // R6

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    (!mode_en && !clr_seen) |=> $stable(occ_count)); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_we |-> (occ_count < CW'(DEPTH))); // R7

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    fifo_re |-> (occ_count != '0)); // R8

  AST_EMPTY_POP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (pop && mode_en && !clr_seen && occ_count == '0) |=> (pop_data == '0)); // R8

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && unmapped) |=> (bus_rdata == '0)); // R3

  AST_STROBE_GATE: assert property (@(posedge clk) disable iff (rst)
    (fifo_we || fifo_re) |-> (mode_en && !clear_wr)); // R12
endmodule

bind fifo_stat_ctrl fsc_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .push      (push),
  .pop       (pop),
  .mode_en   (mode_en),
  .clear_wr  (clear_wr),
  .occ_count (occ_count),
  .ovf_flag  (ovf_flag),
  .unf_flag  (unf_flag),
  .fifo_we   (fifo_we),
  .fifo_re   (fifo_re),
  .pop_data  (pop_data)
);

// File: tb/fifo_stat_ctrl_tb.sv
`timescale 1ns/1ps
module fifo_stat_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       push = 1'b0;
  logic       pop = 1'b0;
  logic [7:0] fifo_rdata = '0;
  logic       frame_end = 1'b0;
  logic       rx_err = 1'b0;
  logic       tx_err = 1'b0;
  logic       fifo_we;
  logic       fifo_re;
  logic [7:0] pop_data;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  fifo_stat_ctrl u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .push(push), .pop(pop), .fifo_rdata(fifo_rdata),
    .frame_end(frame_end), .rx_err(rx_err), .tx_err(tx_err),
    .fifo_we(fifo_we), .fifo_re(fifo_re), .pop_data(pop_data)
  );

  // {requirement number, address, write data, expected read}
  localparam int NV = 13;
  localparam logic [27:0] VEC [NV] = '{
    {4'd2, 4'd1,  8'h80, 8'h80},   // R2 mode
    {4'd2, 4'd2,  8'h09, 8'h09},   // R2 baud
    {4'd2, 4'd3,  8'h5A, 8'h5A},   // R2 control
    {4'd2, 4'd8,  8'hC3, 8'hC3},   // R2 dpll
    {4'd2, 4'd9,  8'h3C, 8'h3C},   // R2 digital
    {4'd4, 4'd4,  8'hFF, 8'hFD},   // R4 revision fixed
    {4'd4, 4'd4,  8'h00, 8'h05},   // R4 revision fixed
    {4'd3, 4'd0,  8'hFF, 8'h00},   // R3 unmapped
    {4'd3, 4'd10, 8'hFF, 8'h00},   // R3 unmapped
    {4'd3, 4'd15, 8'hAA, 8'h00},   // R3 unmapped
    {4'd3, 4'd5,  8'hF7, 8'h04},   // R3 status read-only
    {4'd3, 4'd6,  8'hFF, 8'h00},   // R3 count low read-only
    {4'd3, 4'd7,  8'hFF, 8'h00}    // R3 count high read-only
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    rd_reg(4'd5, d); check("R1 status", d, 8'h04);
    rd_reg(4'd1, d); check("R1 mode", d, 8'h00);
    rd_reg(4'd4, d); check("R1 sensitivity", d, 8'h05);
    rd_reg(4'd6, d); check("R1 count", d, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      wr_reg(VEC[i][19:16], VEC[i][15:8]);
      rd_reg(VEC[i][19:16], d);
      check($sformatf("R%0d vector %0d", VEC[i][27:24], i), d, VEC[i][7:0]);
    end

    // R5 gating: mode bit 1 clear
    wr_reg(4'd1, 8'h00);
    @(negedge clk); push = 1'b1; #1;
    check("R5 we gated", {7'd0, fifo_we}, 8'h00);
    repeat (3) @(negedge clk); push = 1'b0;
    rd_reg(4'd6, d); check("R5 count unchanged", d, 8'h00);

    // R6 R10 R12 pushes
    wr_reg(4'd1, 8'h02);
    @(negedge clk); push = 1'b1; #1;
    check("R12 we on accepted push", {7'd0, fifo_we}, 8'h01);
    repeat (5) @(negedge clk); push = 1'b0;
    rd_reg(4'd6, d); check("R6 count after 5 pushes", d, 8'h05);
    rd_reg(4'd5, d); check("R10 dir after push", d, 8'h10);

    // pops
    fifo_rdata = 8'h3C;
    @(negedge clk); pop = 1'b1; #1;
    check("R12 re on accepted pop", {7'd0, fifo_re}, 8'h01);
    repeat (2) @(negedge clk); pop = 1'b0;
    check("R12 pop data", pop_data, 8'h3C);
    rd_reg(4'd6, d); check("R6 count after pops", d, 8'h03);
    rd_reg(4'd5, d); check("R10 dir after pop", d, 8'h00);

    // simultaneous push and pop
    @(negedge clk); push = 1'b1; pop = 1'b1;
    repeat (4) @(negedge clk); push = 1'b0; pop = 1'b0;
    rd_reg(4'd6, d); check("R6 count both", d, 8'h03);
    rd_reg(4'd5, d); check("R10 dir held", d, 8'h00);

    // R9 clear
    wr_reg(4'd5, 8'h08);
    rd_reg(4'd6, d); check("R9 count cleared", d, 8'h00);
    rd_reg(4'd5, d); check("R9 clear bit reads 0", d, 8'h04);

    // R8 underflow
    fifo_rdata = 8'hEE;
    @(negedge clk); pop = 1'b1; #1;
    check("R8 re refused", {7'd0, fifo_re}, 8'h00);
    @(negedge clk); pop = 1'b0;
    check("R8 pop data zero", pop_data, 8'h00);
    rd_reg(4'd5, d); check("R8 underflow flag", d, 8'h44);
    rd_reg(4'd6, d); check("R8 count stays", d, 8'h00);
    wr_reg(4'd5, 8'h08);
    rd_reg(4'd5, d); check("R9 underflow cleared", d, 8'h04);

    // R7 fill and overflow
    @(negedge clk); push = 1'b1;
    repeat (4096) @(negedge clk); push = 1'b0;
    rd_reg(4'd6, d); check("R6 full low byte", d, 8'h00);
    rd_reg(4'd7, d); check("R6 full high byte", d, 8'h10);
    rd_reg(4'd5, d); check("R11 not empty", d, 8'h10);
    @(negedge clk); push = 1'b1; #1;
    check("R7 we refused when full", {7'd0, fifo_we}, 8'h00);
    @(negedge clk); push = 1'b0;
    rd_reg(4'd5, d); check("R7 overflow flag", d, 8'h30);
    rd_reg(4'd7, d); check("R7 count held", d, 8'h10);

    // R11 pass-through bits
    frame_end = 1'b1; rx_err = 1'b1; tx_err = 1'b1;
    rd_reg(4'd5, d); check("R11 inputs in status", d, 8'hB3);
    frame_end = 1'b0; rx_err = 1'b0; tx_err = 1'b0;

    // R9 clear beats a same-cycle push
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 4'd5; bus_wdata = 8'h08; push = 1'b1; #1;
    check("R9 push dropped on clear", {7'd0, fifo_we}, 8'h00);
    @(negedge clk); bus_wr = 1'b0; push = 1'b0;
    rd_reg(4'd6, d); check("R9 count zero", d, 8'h00);
    rd_reg(4'd7, d); check("R9 count high zero", d, 8'h00);
    rd_reg(4'd5, d); check("R9 flags cleared", d, 8'h14);

    finish_run();
  end
endmodule